// File: doc/BRIEF.md
# Overlapping 1011 Serial Recognizer

This block watches a single serial data line, one bit per clock edge, and raises a one-bit match flag when the four most recent accepted bits, oldest first, are 1, 0, 1, 1. Internally it is a four-state machine held in two flip-flops. The states record how much of the target has been seen so far: nothing, "1", "10" or "101". The flag is a Mealy output. It goes high during the cycle in which the completing 1 is on the input. It does not wait for the next edge.

The recognizer keeps partial progress after a hit, so a match can begin with the last 1 of the previous match. A strobe marks which cycles carry a real bit. When the strobe is low, the machine keeps its state and the flag stays low. A synchronous, active-high reset takes it back to the empty state.

Top module: `serial_match_fsm`

## Requirements
- R1: While `rst` is high the flag `hit` is 0. The first clock edge with `rst` high returns the machine to the empty state, so no bit accepted before reset can count toward a later match.
- R2: `hit` is 1 in a cycle exactly when `bit_valid` is 1, `bit_in` is 1, and the three previously accepted bits, oldest first, were 1, 0, 1. The flag is combinational in that cycle.
- R3: Matches may overlap. For the accepted stream 1,0,1,1,0,1,1 the flag fires on the 4th and 7th bits only.
- R4: In a cycle with `bit_valid` low, `hit` is 0 and the match progress is unchanged. A later accepted bit therefore continues the match as if the idle cycles were absent.
- R5: After a hit the machine holds state "1". A following 0,1,1 gives another hit.
- R6: From state "101", an accepted 0 leads to state "10". The stream 1,0,1,0,1,1 hits on its 6th bit.
- R7: In state "1", further 1s keep the machine in state "1". In state "10", a 0 returns it to the empty state. For example, 1,1,1,0,1,1 hits on the 6th bit and 1,0,0,1,1 never hits.
- R8: For the accepted stream 1110010010011011010110111111, counting bits from 1, the flag is 1 on bits 16, 21 and 24 and 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High in the cycle the completing bit of 1011 is presented |

## Verification
The bench aims at the cases where a plausible machine drifts from the true sliding-window behaviour:
- The "101" followed by 0 fallback: a design that falls back to the empty state would miss the hit in 1,0,1,0,1,1.
- The post-hit state: a design that clears all progress on a hit would lose the second match of 1011011.
- Idle strobe cycles: a design that advances or flags while the strobe is low would fire early or lose its progress.
- Reset during a partial match, checked at the flag: a late or ineffective reset lets a stale prefix complete a false match.
- The flag's timing: a registered flag would show up one cycle late on every hit.

// File: rtl/srm_pkg.sv
package srm_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_A     = 2'b01,   // "1" seen
    ST_AB    = 2'b10,   // "10" seen
    ST_ABA   = 2'b11    // "101" seen
  } srm_state_t;

  // Progress after accepting one bit
  function automatic srm_state_t srm_advance(input srm_state_t s, input logic b);
    srm_state_t n;
    unique case (s)
      ST_IDLE: n = b ? ST_A   : ST_IDLE;
      ST_A:    n = b ? ST_A   : ST_AB;
      ST_AB:   n = b ? ST_ABA : ST_IDLE;
      ST_ABA:  n = b ? ST_A   : ST_AB;
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction

  // True when this bit closes the pattern
  function automatic logic srm_completes(input srm_state_t s, input logic b);
    return (s == ST_ABA) && b;
  endfunction

endpackage

// File: rtl/srm_parts.sv
module srm_next
  import srm_pkg::*;
(
  input  srm_state_t cur,
  input  logic       valid,
  input  logic       din,
  output srm_state_t nxt,
  output logic       closes
);
  always_comb begin
    if (valid) begin
      nxt    = srm_advance(cur, din);
      closes = srm_completes(cur, din);
    end else begin
      nxt    = cur;
      closes = 1'b0;
    end
  end
endmodule

module srm_state_reg
  import srm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  srm_state_t nxt,
  output srm_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end
endmodule

module srm_out (
  input  logic rst,
  input  logic closes,
  output logic flag
);
  assign flag = closes & ~rst;
endmodule

// File: rtl/serial_match_fsm.sv
module serial_match_fsm
  import srm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic hit
);
  srm_state_t cur_state;
  srm_state_t nxt_state;
  logic       closes_now;

  srm_next u_next (
    .cur    (cur_state),
    .valid  (bit_valid),
    .din    (bit_in),
    .nxt    (nxt_state),
    .closes (closes_now)
  );

  srm_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  srm_out u_out (
    .rst    (rst),
    .closes (closes_now),
    .flag   (hit)
  );
endmodule

// File: rtl/srm_checker.sv
module srm_checker
  import srm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_in,
  input logic       hit,
  input srm_state_t cur_state
);
  always_comb begin
    if (rst) AST_RST_QUIET: assert (!hit); // R1
  end

  AST_HIT_AFTER_PREFIX: assert property (@(posedge clk) disable iff (rst)
    hit |-> (cur_state == ST_ABA && bit_in && bit_valid)); // R2

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> !hit); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(cur_state)); // R4

  AST_POST_HIT_ONE: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cur_state == ST_A)); // R5

  AST_FALLBACK_TEN: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in && cur_state == ST_ABA) |=> (cur_state == ST_AB)); // R6

  AST_ONES_STAY: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && cur_state == ST_A) |=> (cur_state == ST_A)); // R7
endmodule

bind serial_match_fsm srm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .hit       (hit),
  .cur_state (cur_state)
);

// File: tb/sim_serial_match_fsm.sv
`timescale 1ns/1ps
module sim_serial_match_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic hit;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int hist[$];
  int hit_pos[$];

  always #5 clk = ~clk;

  serial_match_fsm u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .hit(hit)
  );

  function automatic logic model_hit(input logic v, input logic b, input logic r);
    if (r || !v || !b || hist.size() < 3) return 1'b0;
    return hist[hist.size()-3] == 1 && hist[hist.size()-2] == 0 &&
           hist[hist.size()-1] == 1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: hit=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after falling edge, compare before rising edge
  task automatic step(input logic r, input logic v, input logic b, input string tag);
    logic exp;
    @(negedge clk);
    rst = r; bit_valid = v; bit_in = b;
    #2;
    exp = model_hit(v, b, r);
    check(tag, hit, exp);
    if (r) hist.delete();
    else if (v) begin
      hist.push_back(int'(b));
      if (hist.size() > 3) void'(hist.pop_front());
    end
  endtask

  task automatic feed(input string bits, input string tag);
    for (int i = 0; i < bits.len(); i++) step(1'b0, 1'b1, bits[i] == "1", tag);
  endtask

  task automatic expect_hit(input string tag, input logic exp);
    check(tag, hit, exp);
  endtask

  initial begin
    step(1'b1, 1'b1, 1'b1, "R1 reset");
    step(1'b1, 1'b0, 1'b0, "R1 reset");
    feed("1011", "R2 basic");
    feed("1011011", "R3 overlap");
    feed("0", "R7 flush");
    feed("101", "R4 prefix");
    step(1'b0, 1'b0, 1'b1, "R4 idle");
    step(1'b0, 1'b0, 1'b0, "R4 idle");
    step(1'b0, 1'b0, 1'b1, "R4 idle");
    @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1; #2;
    expect_hit("R4 resume after idle", 1'b1);
    hist.push_back(1); void'(hist.pop_front());
    feed("011", "R5 post hit");
    feed("00", "R7 flush");
    feed("101011", "R6 fallback");
    feed("00", "R7 flush");
    feed("111011", "R7 ones stay");
    feed("10011", "R7 ten zero");
    feed("00", "R7 flush");
    feed("101", "R1 stale prefix");
    step(1'b1, 1'b1, 1'b1, "R1 reset mid match");
    feed("1", "R1 after reset");
    feed("00", "R7 flush");
    begin
      string s;
      s = "1110010010011011010110111111";
      for (int i = 0; i < s.len(); i++) begin
        step(1'b0, 1'b1, s[i] == "1", "R8 long stream");
        if (hit) hit_pos.push_back(i + 1);
      end
      checks++;
      if (hit_pos.size() != 3 || hit_pos[0] != 16 || hit_pos[1] != 21 || hit_pos[2] != 24) begin
        fails++;
        $display("FAIL R8: hit positions %p expected '{16,21,24}", hit_pos);
      end
    end
    step(1'b0, 1'b0, 1'b0, "R4 idle tail");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule